// File: doc/BRIEF.md
# Oversampling Serial Receiver with Noise Detection

This block receives asynchronous serial data in 8N1 format: one start bit, eight data bits sent least significant bit first, and one stop bit. The line passes through a two-stage synchronizer. It is then examined on a sample tick taken from a programmable prescaler, and each bit period lasts sixteen ticks. A falling edge starts a frame. Within each bit, the tick that first sees the low level of the start edge is position 1, and positions run from 1 to 16.

A mode input selects how each bit level is decided. In vote mode the level is the majority of the samples at positions 8, 9 and 10, and any disagreement among those three samples marks the frame as noisy. In single mode only the position-9 sample is used, and the frame is never marked noisy. A noisy frame is still delivered. The received byte moves to an output register and a ready flag rises. On that same cycle the noise flag rises if the frame was noisy, and a framing flag rises if the stop bit was low. The ready flag clears when the byte is read. The two error flags clear only through a write-one-to-clear strobe. An error interrupt output reports those flags only while it is enabled.

Top module: `uart_os_rx`

## Requirements
- R1: A sample tick occurs once every `presc_div`+1 clocks, and one bit lasts 16 ticks. Frames are received correctly when `presc_div` is 0 and when it is 3.
- R2: With `onebit_mode`=0, each bit takes the majority of its samples at positions 8, 9 and 10. Samples at any other position have no effect on the value or on the noise flag.
- R3: With `onebit_mode`=0, a frame in which the three vote samples of any bit disagree sets `noise_flag`.
- R4: With `onebit_mode`=1, each bit takes its value from the position-9 sample alone, and `noise_flag` is never set.
- R5: `noise_flag` rises on the same clock that `data_ready` rises for the noisy frame, and the noisy byte is still written to `rx_data`.
- R6: `noise_flag` clears only when `clr_wr`=1 with `clr_mask[0]`=1. `frame_err` clears only when `clr_wr`=1 with `clr_mask[1]`=1. A read strobe affects neither flag.
- R7: `err_irq` is high exactly when `err_irq_en`=1 and either `noise_flag` or `frame_err` is set.
- R8: A start edge whose mid-bit decision is high is dropped. No byte is delivered, `rx_data` keeps its value, and the next valid frame is received normally.
- R9: Data arrives LSB first as 8 data bits followed by 1 stop bit. A low stop bit sets `frame_err`, and the byte is still delivered. `rx_data` changes only when a frame is delivered.
- R10: A one-clock `rd_strobe` clears `data_ready`.
- R11: After reset `data_ready`, `noise_flag`, `frame_err` and `err_irq` are 0, and `rx_data` is 0.
- R12: Vote disagreement in the start bit or in the stop bit also sets `noise_flag` for that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| presc_div | input | PRESC_W | Sample tick every presc_div+1 clocks |
| onebit_mode | input | 1 | 0: three-sample vote, 1: single centre sample |
| err_irq_en | input | 1 | Enables the error interrupt output |
| rx_i | input | 1 | Serial line, idle high |
| rd_strobe | input | 1 | Read of the data register, clears ready |
| clr_wr | input | 1 | Write strobe for flag clearing |
| clr_mask | input | 2 | Bit 0 clears the noise flag, bit 1 clears the framing flag |
| rx_data | output | DATA_W | Last received byte |
| data_ready | output | 1 | A byte is waiting |
| noise_flag | output | 1 | Sticky noise indication |
| frame_err | output | 1 | Sticky framing error |
| err_irq | output | 1 | Error interrupt |

## Verification
The assertions assume three things about the inputs. `onebit_mode` is held steady while a frame is in progress, so the mode seen when a flag is set is the mode of that frame. Clears and reads are single-clock strobes. Reset is applied before any check counts. The bench changes mode, prescaler and enable only while the line is idle between frames. It drives each glitch for exactly one tick with the prescaler at 0, so every injected disturbance reaches a known sample position. Frames with the prescaler at 3 carry no glitches, so the unknown tick phase cannot move a sample across a bit edge.

// File: rtl/osr_pkg.sv
// Shared constants and types for the oversampling receiver.
// Assumes 16 ticks per bit with the centre samples at positions 8, 9 and 10.
package osr_pkg;
    localparam int unsigned BIT_TICKS = 16;
    localparam int unsigned POS_W     = $clog2(BIT_TICKS + 1);
    localparam int unsigned VOTE_A    = 8;
    localparam int unsigned VOTE_B    = 9;
    localparam int unsigned VOTE_C    = 10;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;
endpackage

// File: rtl/osr_tick_gen.sv
// Produces a one-clock sample tick every div+1 clocks.
// Assumes div changes only while the receiver is idle.
module osr_tick_gen #(
    parameter int unsigned PRESC_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PRESC_W-1:0] div,
    output logic               tick
);
    logic [PRESC_W-1:0] cnt;

    assign tick = (cnt >= div);

    // Free-running prescale counter that wraps at div.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/osr_sync.sv
// Multi-stage synchronizer for the asynchronous serial line.
// Assumes the line idles high; the stages reset to 1.
module osr_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Stage 0 captures the raw input.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b1;
        else        chain[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        // Each further stage retimes the previous one.
        always_ff @(posedge clk) begin
            if (!rst_n) chain[i] <= 1'b1;
            else        chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/osr_bit_vote.sv
// Holds the first two centre samples of a bit. When the third sample is live
// it resolves the bit by majority or by the middle sample, and it flags
// disagreement in vote mode.
// Assumes the result is used only at position VOTE_C.
module osr_bit_vote
    import osr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [POS_W-1:0] pos,
    input  logic             lvl,
    input  logic             onebit,
    output logic             bit_val,
    output logic             bit_noise
);
    logic samp_a, samp_b;
    logic maj, agree;

    // Capture the samples at the first two centre positions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_a <= 1'b1;
            samp_b <= 1'b1;
        end else if (tick) begin
            if (pos == POS_W'(VOTE_A)) samp_a <= lvl;
            if (pos == POS_W'(VOTE_B)) samp_b <= lvl;
        end
    end

    // Resolve the bit value and its noise indication.
    always_comb begin
        maj       = (samp_a & samp_b) | (samp_a & lvl) | (samp_b & lvl);
        agree     = (samp_a == samp_b) && (samp_b == lvl);
        bit_val   = onebit ? samp_b : maj;
        bit_noise = !onebit && !agree;
    end
endmodule

// File: rtl/osr_frame.sv
// Frame sequencer: detects the start edge, validates the start bit at mid-bit,
// shifts in data LSB first and completes the frame at the stop-bit centre.
// Assumes lvl is already synchronized and that tick marks the sample points.
module osr_frame
    import osr_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              lvl,
    input  logic              bit_val,
    input  logic              bit_noise,
    output logic [POS_W-1:0]  pos,
    output logic              frame_done,
    output logic [DATA_W-1:0] frame_byte,
    output logic              frame_noise,
    output logic              stop_bad
);
    localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    rx_state_e         state;
    logic [CNT_W-1:0]  bitn;
    logic              noise_acc;
    logic              prev_lvl;
    logic              at_centre, at_end;

    assign at_centre   = tick && (pos == POS_W'(VOTE_C));
    assign at_end      = tick && (pos == POS_W'(BIT_TICKS));
    assign frame_done  = at_centre && (state == RX_STOP);
    assign frame_noise = noise_acc | bit_noise;
    assign stop_bad    = !bit_val;

    // Sequence through start, data and stop bits on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= RX_IDLE;
            pos        <= '0;
            bitn       <= '0;
            noise_acc  <= 1'b0;
            prev_lvl   <= 1'b1;
            frame_byte <= '0;
        end else if (tick) begin
            prev_lvl <= lvl;
            if (state == RX_IDLE) begin
                if (prev_lvl && !lvl) begin
                    state     <= RX_START;
                    pos       <= POS_W'(2);
                    noise_acc <= 1'b0;
                end
            end else begin
                pos <= at_end ? POS_W'(1) : pos + 1'b1;
                if (at_centre) begin
                    case (state)
                        RX_START: begin
                            if (bit_val) state <= RX_IDLE;
                            noise_acc <= bit_noise;
                        end
                        RX_DATA: begin
                            frame_byte <= {bit_val, frame_byte[DATA_W-1:1]};
                            noise_acc  <= noise_acc | bit_noise;
                        end
                        default: state <= RX_IDLE;
                    endcase
                end
                if (at_end) begin
                    if (state == RX_START) begin
                        state <= RX_DATA;
                        bitn  <= '0;
                    end else if (state == RX_DATA) begin
                        if (bitn == CNT_W'(DATA_W - 1)) state <= RX_STOP;
                        bitn <= bitn + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/uart_os_rx.sv
// Top of the oversampling serial receiver. Owns the delivered byte and the
// ready, noise and framing flags; a new frame wins over a same-cycle clear.
// Assumes onebit_mode and presc_div change only while the line is idle.
module uart_os_rx
    import osr_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned PRESC_W     = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PRESC_W-1:0] presc_div,
    input  logic              onebit_mode,
    input  logic              err_irq_en,
    input  logic              rx_i,
    input  logic              rd_strobe,
    input  logic              clr_wr,
    input  logic [1:0]        clr_mask,
    output logic [DATA_W-1:0] rx_data,
    output logic              data_ready,
    output logic              noise_flag,
    output logic              frame_err,
    output logic              err_irq
);
    logic              tick, lvl, bit_val, bit_noise;
    logic [POS_W-1:0]  pos;
    logic              frame_done, frame_noise, stop_bad;
    logic [DATA_W-1:0] frame_byte;
    logic              clr_noise, clr_frame;

    osr_tick_gen #(.PRESC_W(PRESC_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .div(presc_div), .tick(tick)
    );

    osr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(rx_i), .q(lvl)
    );

    osr_bit_vote u_vote (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pos(pos), .lvl(lvl),
        .onebit(onebit_mode), .bit_val(bit_val), .bit_noise(bit_noise)
    );

    osr_frame #(.DATA_W(DATA_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .tick(tick), .lvl(lvl),
        .bit_val(bit_val), .bit_noise(bit_noise), .pos(pos),
        .frame_done(frame_done), .frame_byte(frame_byte),
        .frame_noise(frame_noise), .stop_bad(stop_bad)
    );

    assign clr_noise = clr_wr && clr_mask[0];
    assign clr_frame = clr_wr && clr_mask[1];
    assign err_irq   = err_irq_en && (noise_flag || frame_err);

    // Latch a finished frame and keep the sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data    <= '0;
            data_ready <= 1'b0;
            noise_flag <= 1'b0;
            frame_err  <= 1'b0;
        end else begin
            if (frame_done) rx_data <= frame_byte;
            data_ready <= frame_done || (data_ready && !rd_strobe);
            noise_flag <= (frame_done && frame_noise) || (noise_flag && !clr_noise);
            frame_err  <= (frame_done && stop_bad) || (frame_err && !clr_frame);
        end
    end
endmodule

// File: rtl/uart_os_rx_checker.sv
// Port-level properties of the receiver, attached by bind.
// Assumes onebit_mode is steady across a frame.
module uart_os_rx_checker #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              onebit_mode,
    input logic              rd_strobe,
    input logic              clr_wr,
    input logic [1:0]        clr_mask,
    input logic [DATA_W-1:0] rx_data,
    input logic              data_ready,
    input logic              noise_flag,
    input logic              frame_err
);
    // The noise flag never rises for a frame decided in single mode.
    p_single_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(noise_flag) |-> !$past(onebit_mode));

    // The noise flag rises only together with a delivered byte.
    p_noise_with_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(noise_flag) |-> data_ready);

    // The noise flag falls only after a write-one to its clear bit.
    p_noise_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(noise_flag) |-> $past(clr_wr && clr_mask[0]));

    // The framing flag falls only after a write-one to its clear bit.
    p_ferr_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_err) |-> $past(clr_wr && clr_mask[1]));

    // The data register changes only along with a delivered frame.
    p_data_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_data) |-> data_ready);

    // Ready falls only after a read strobe.
    p_ready_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_ready) |-> $past(rd_strobe));
endmodule

bind uart_os_rx uart_os_rx_checker #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .onebit_mode(onebit_mode),
    .rd_strobe(rd_strobe), .clr_wr(clr_wr), .clr_mask(clr_mask),
    .rx_data(rx_data), .data_ready(data_ready),
    .noise_flag(noise_flag), .frame_err(frame_err)
);

// File: tb/uart_os_rx_bench.sv
// Sweeping bench: drives 8N1 frames with optional one-tick glitches at chosen
// sample positions and checks delivered data and flags against values
// computed from the requirements.
module uart_os_rx_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] presc_div = '0;
    logic       onebit_mode = 1'b0;
    logic       err_irq_en = 1'b0;
    logic       rx_i = 1'b1;
    logic       rd_strobe = 1'b0;
    logic       clr_wr = 1'b0;
    logic [1:0] clr_mask = '0;
    logic [7:0] rx_data;
    logic       data_ready, noise_flag, frame_err, err_irq;

    int total = 0;
    int bad = 0;
    logic seen_dr, nf_at_dr, fe_at_dr;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_os_rx u_uart_os_rx (
        .clk(clk), .rst_n(rst_n), .presc_div(presc_div),
        .onebit_mode(onebit_mode), .err_irq_en(err_irq_en), .rx_i(rx_i),
        .rd_strobe(rd_strobe), .clr_wr(clr_wr), .clr_mask(clr_mask),
        .rx_data(rx_data), .data_ready(data_ready), .noise_flag(noise_flag),
        .frame_err(frame_err), .err_irq(err_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one frame; a glitch inverts the line at masked positions of bit gbit
    // (0 = start, 1..8 = data, 9 = stop).
    task automatic send(input logic [7:0] d, input logic stopv, input int gbit,
                        input logic [15:0] gmask);
        for (int b = 0; b < 10; b++) begin
            logic nom;
            nom = (b == 0) ? 1'b0 : (b == 9) ? stopv : d[b-1];
            for (int k = 0; k < 16; k++) begin
                @(negedge clk);
                rx_i = nom ^ ((b == gbit) && gmask[k]);
                repeat (presc_div) @(negedge clk);
            end
        end
        @(negedge clk);
        rx_i = 1'b1;
        repeat (8 * (presc_div + 1)) @(negedge clk);
    endtask

    // Record the flags on the first clock where data_ready is seen high.
    task automatic watch(input int max_clk);
        seen_dr = 1'b0;
        nf_at_dr = 1'b0;
        fe_at_dr = 1'b0;
        for (int i = 0; i < max_clk && !seen_dr; i++) begin
            @(negedge clk);
            if (data_ready) begin
                seen_dr = 1'b1;
                nf_at_dr = noise_flag;
                fe_at_dr = frame_err;
            end
        end
    endtask

    task automatic clear_all();
        @(negedge clk);
        rd_strobe = 1'b1; clr_wr = 1'b1; clr_mask = 2'b11;
        @(negedge clk);
        rd_strobe = 1'b0; clr_wr = 1'b0; clr_mask = 2'b00;
    endtask

    task automatic frame(input string tag, input logic [7:0] d, input logic stopv,
                         input int gbit, input logic [15:0] gmask,
                         input logic [7:0] exp_d, input logic exp_n, input logic exp_f,
                         input logic do_clear);
        fork
            send(d, stopv, gbit, gmask);
            watch(200 * (presc_div + 1));
        join
        chk({tag, " ready"}, {31'd0, seen_dr}, 32'd1);
        chk({tag, " data"}, {24'd0, rx_data}, {24'd0, exp_d});
        chk({tag, " noise"}, {31'd0, nf_at_dr}, {31'd0, exp_n});
        chk({tag, " frame"}, {31'd0, fe_at_dr}, {31'd0, exp_f});
        if (do_clear) clear_all();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R11: reset state
        chk("R11 ready", {31'd0, data_ready}, 32'd0);
        chk("R11 noise", {31'd0, noise_flag}, 32'd0);
        chk("R11 frame", {31'd0, frame_err}, 32'd0);
        chk("R11 irq", {31'd0, err_irq}, 32'd0);
        chk("R11 data", {24'd0, rx_data}, 32'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 R9: every byte, prescaler 0, vote mode
        for (int v = 0; v < 256; v++)
            frame("R9 sweep", 8'(v), 1'b1, -1, 16'h0, 8'(v), 1'b0, 1'b0, 1'b1);

        // R1: slower tick
        presc_div = 4'd3;
        for (int v = 5; v < 256; v += 17)
            frame("R1 div3", 8'(v), 1'b1, -1, 16'h0, 8'(v), 1'b0, 1'b0, 1'b1);
        presc_div = 4'd0;

        // R2 R3: single glitched vote sample on data bit 3 (mask bit k = position k+1)
        frame("R3 glitch p8",  8'hA5, 1'b1, 4, 16'h0080, 8'hA5, 1'b1, 1'b0, 1'b1);
        frame("R3 glitch p9",  8'hA5, 1'b1, 4, 16'h0100, 8'hA5, 1'b1, 1'b0, 1'b1);
        frame("R3 glitch p10", 8'hA5, 1'b1, 4, 16'h0200, 8'hA5, 1'b1, 1'b0, 1'b1);
        frame("R2 two p8p9",   8'hA5, 1'b1, 4, 16'h0180, 8'hAD, 1'b1, 1'b0, 1'b1);
        frame("R2 two p9p10",  8'h3C, 1'b1, 4, 16'h0300, 8'h34, 1'b1, 1'b0, 1'b1);
        frame("R2 off p5",     8'h3C, 1'b1, 4, 16'h0010, 8'h3C, 1'b0, 1'b0, 1'b1);
        frame("R2 off p11",    8'h3C, 1'b1, 4, 16'h0400, 8'h3C, 1'b0, 1'b0, 1'b1);

        // R12: disagreement in start and stop bits
        frame("R12 start", 8'h5A, 1'b1, 0, 16'h0100, 8'h5A, 1'b1, 1'b0, 1'b1);
        frame("R12 stop",  8'h5A, 1'b1, 9, 16'h0200, 8'h5A, 1'b1, 1'b0, 1'b1);

        // R4: single-sample mode
        onebit_mode = 1'b1;
        frame("R4 p9 flips",  8'hA5, 1'b1, 4, 16'h0100, 8'hAD, 1'b0, 1'b0, 1'b1);
        frame("R4 p8 quiet",  8'hA5, 1'b1, 4, 16'h0080, 8'hA5, 1'b0, 1'b0, 1'b1);
        frame("R4 p8p10",     8'hA5, 1'b1, 4, 16'h0280, 8'hA5, 1'b0, 1'b0, 1'b1);
        frame("R4 stop p10",  8'h11, 1'b1, 9, 16'h0200, 8'h11, 1'b0, 1'b0, 1'b1);
        onebit_mode = 1'b0;

        // R9: low stop bit gives framing error with data delivered
        frame("R9 stop low", 8'hC3, 1'b0, -1, 16'h0, 8'hC3, 1'b0, 1'b1, 1'b1);

        // R5 R6 R7 R10: noisy frame left uncleared
        frame("R5 keep", 8'h96, 1'b1, 2, 16'h0200, 8'h96, 1'b1, 1'b0, 1'b0);
        err_irq_en = 1'b0;
        @(negedge clk);
        chk("R7 irq masked", {31'd0, err_irq}, 32'd0);
        err_irq_en = 1'b1;
        @(negedge clk);
        chk("R7 irq on", {31'd0, err_irq}, 32'd1);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        @(negedge clk);
        chk("R10 ready cleared", {31'd0, data_ready}, 32'd0);
        chk("R6 noise after read", {31'd0, noise_flag}, 32'd1);
        clr_wr = 1'b1; clr_mask = 2'b10;
        @(negedge clk);
        clr_wr = 1'b0; clr_mask = 2'b00;
        @(negedge clk);
        chk("R6 noise wrong bit", {31'd0, noise_flag}, 32'd1);
        clr_wr = 1'b1; clr_mask = 2'b01;
        @(negedge clk);
        clr_wr = 1'b0; clr_mask = 2'b00;
        @(negedge clk);
        chk("R6 noise cleared", {31'd0, noise_flag}, 32'd0);
        chk("R7 irq off", {31'd0, err_irq}, 32'd0);

        // R6: framing flag clears only through bit 1
        frame("R6 ferr", 8'h0F, 1'b0, -1, 16'h0, 8'h0F, 1'b0, 1'b1, 1'b0);
        chk("R7 irq ferr", {31'd0, err_irq}, 32'd1);
        clr_wr = 1'b1; clr_mask = 2'b01;
        @(negedge clk);
        clr_wr = 1'b0; clr_mask = 2'b00;
        @(negedge clk);
        chk("R6 ferr kept", {31'd0, frame_err}, 32'd1);
        clr_wr = 1'b1; clr_mask = 2'b10;
        @(negedge clk);
        clr_wr = 1'b0; clr_mask = 2'b00;
        @(negedge clk);
        chk("R6 ferr cleared", {31'd0, frame_err}, 32'd0);
        clear_all();

        // R8: false start of 5 ticks is dropped
        rx_i = 1'b0;
        repeat (5) @(negedge clk);
        rx_i = 1'b1;
        repeat (300) @(negedge clk);
        chk("R8 no ready", {31'd0, data_ready}, 32'd0);
        chk("R8 data kept", {24'd0, rx_data}, 32'h0F);
        chk("R8 no noise", {31'd0, noise_flag}, 32'd0);
        frame("R8 next ok", 8'h7E, 1'b1, -1, 16'h0, 8'h7E, 1'b0, 1'b0, 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule